// File: doc/BRIEF.md
# Shadow-Copy Store and Recall Sequencer

This block sits beside the SRAM array of a nonvolatile SRAM and decides when the array is copied into its shadow nonvolatile cells (a store) and when the shadow copy is loaded back into the array (a recall). Three sources can ask for a store: a supply fault reported by the power-good comparator, an external pull-down on the shared active-low store/busy line, and a software request. A recall starts by itself each time power-good rises. Software can also ask for one.

The block keeps a modified flag that records whether the array has been written since the last store or recall. A store request is skipped when the array is clean. While a store or recall runs, the block pulls the shared store/busy line low and blocks every array access. It uses the read strobe as the enable for the array's data drivers, so the bus stays undriven during that time. The durations of the two nonvolatile operations come from cycle-count parameters.

When power returns, array writes stay blocked until the host gives a fresh falling edge on write enable. This protects the array against writes that only look valid while the supply is settling. All pins are plain control and status signals with no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `nvstore_ctrl`

## Requirements
- R1: While powered down, a rise of `pwr_ok` starts a recall on the next clock edge. `recall_run` and `hsb_pull` are then high for exactly RECALL_CYC cycles, after which the block is idle.
- R2: When `pwr_ok` falls while idle with `dirty`=1, a store starts on the next edge and lasts exactly STORE_CYC cycles even though power is gone. The block then powers down: no run flags, no busy pull, and no array access.
- R3: When `pwr_ok` falls while idle with `dirty`=0, no store runs. The block powers down on the next edge and `hsb_pull` stays low.
- R4: While idle and powered with `dirty`=1, a low level on `hsb_n_in` or a one-cycle `sw_store` pulse starts a store of exactly STORE_CYC cycles, after which the block is idle again.
- R5: A store request from `hsb_n_in` or `sw_store` while `dirty`=0 starts no store, and `hsb_pull` stays low.
- R6: `sram_rd` is high only when the block is idle, `ce_n`=0, `oe_n`=0, `we_n`=1 and `hsb_n_in`=1. `sram_rd` and `sram_wr` are never high together.
- R7: `sram_wr` is high only when the block is idle, `ce_n`=0, `we_n`=0, `hsb_n_in`=1 and writes are unlocked. A blocked write leaves `dirty` unchanged.
- R8: Each power-up recall locks writes. The lock clears on the first 1-to-0 transition of `we_n` seen while idle, and the write in the cycle of that transition is accepted. Holding `we_n` low through the recall does not unlock.
- R9: `dirty` is 0 after reset. It becomes 1 on the edge after any accepted write, and becomes 0 on the edge that ends a store or a recall.
- R10: While idle, a `sw_recall` pulse starts a recall of exactly RECALL_CYC cycles, and that recall clears `dirty`.
- R11: While a store or recall runs, `hsb_pull` is high and `sram_rd` and `sram_wr` are low. Requests that arrive then are not queued: a store request during a recall is settled when the recall ends, and because the array is then clean no store runs.
- R12: When `sw_store` and `sw_recall` arrive together while idle with `dirty`=1, the store runs and the recall request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; the block starts powered down |
| pwr_ok | input | 1 | Supply above sense threshold |
| hsb_n_in | input | 1 | Level of the shared active-low store/busy line |
| sw_store | input | 1 | Software store request pulse |
| sw_recall | input | 1 | Software recall request pulse |
| ce_n | input | 1 | Array chip enable, active low |
| oe_n | input | 1 | Array output enable, active low |
| we_n | input | 1 | Array write enable, active low |
| hsb_pull | output | 1 | Pull the store/busy line low (open-drain drive) |
| store_run | output | 1 | Store to shadow cells in progress |
| recall_run | output | 1 | Recall from shadow cells in progress |
| sram_rd | output | 1 | Read strobe and data-bus drive enable |
| sram_wr | output | 1 | Write strobe to the array |
| dirty | output | 1 | Array written since the last store or recall |

## Verification
The assertions check the per-cycle rules on every clock: a store is entered only from a modified array, a powered-down block answers power-good with a recall, and a power loss while idle leads to a store or a power-down. They also check that the modified flag follows accepted writes and completed operations, and that busy excludes any array access. The bench scenarios are needed to show exact operation lengths, the write lockout after power-up and its release on a fresh falling edge, the priority of store over recall, and that a request made during a recall leaves no trace.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [1:0] {
    ST_DOWN   = 2'd0,
    ST_RECALL = 2'd1,
    ST_IDLE   = 2'd2,
    ST_STORE  = 2'd3
  } nv_state_t;
endpackage

// File: rtl/nvc_timer.sv
module nvc_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvc_seq.sv
module nvc_seq
  import nvc_pkg::*;
#(
  parameter int STORE_CYC  = 8,
  parameter int RECALL_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_ok,
  input  logic      store_req,
  input  logic      recall_req,
  input  logic      dirty,
  output nv_state_t state,
  output logic      nv_done,
  output logic      power_up
);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ST_LOAD = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RC_LOAD = CW'(RECALL_CYC - 1);

  nv_state_t     state_q, nxt;
  logic          load, expired;
  logic [CW-1:0] load_val;

  nvc_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  always_comb begin
    nxt      = state_q;
    load     = 1'b0;
    load_val = '0;
    nv_done  = 1'b0;
    power_up = 1'b0;
    unique case (state_q)
      ST_DOWN: if (pwr_ok) begin
        nxt = ST_RECALL; load = 1'b1; load_val = RC_LOAD; power_up = 1'b1;
      end
      ST_IDLE: begin
        if (!pwr_ok) begin
          if (dirty) begin nxt = ST_STORE; load = 1'b1; load_val = ST_LOAD; end
          else nxt = ST_DOWN;
        end else if (store_req && dirty) begin
          nxt = ST_STORE; load = 1'b1; load_val = ST_LOAD;
        end else if (recall_req) begin
          nxt = ST_RECALL; load = 1'b1; load_val = RC_LOAD;
        end
      end
      ST_STORE, ST_RECALL: if (expired) begin
        nv_done = 1'b1;
        nxt = pwr_ok ? ST_IDLE : ST_DOWN;
      end
      default: nxt = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_DOWN;
    else        state_q <= nxt;
  end

  assign state = state_q;

  p_store_needs_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE && $past(state_q) != ST_STORE) |-> $past(dirty));
  p_powerup_recall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOWN && pwr_ok) |=> state_q == ST_RECALL);
  p_powerfail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !pwr_ok) |=> (state_q == ST_STORE || state_q == ST_DOWN));
  p_clean_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !pwr_ok && !dirty) |=> state_q == ST_DOWN);
endmodule

// File: rtl/nvc_access.sv
module nvc_access (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic power_up,
  input  logic nv_done,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic hsb_n_in,
  output logic sram_rd,
  output logic sram_wr,
  output logic dirty
);
  logic we_q, lock_q, dirty_q, we_fall;

  assign we_fall = we_q & ~we_n;
  assign sram_rd = idle & ~ce_n & ~oe_n & we_n & hsb_n_in;
  assign sram_wr = idle & ~ce_n & ~we_n & hsb_n_in & (~lock_q | we_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      lock_q  <= 1'b1;
      dirty_q <= 1'b0;
    end else begin
      we_q <= we_n;
      if (power_up)             lock_q <= 1'b1;
      else if (idle && we_fall) lock_q <= 1'b0;
      if (nv_done)      dirty_q <= 1'b0;
      else if (sram_wr) dirty_q <= 1'b1;
    end
  end

  assign dirty = dirty_q;

  p_dirty_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr |=> dirty_q);
  p_dirty_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nv_done |=> !dirty_q);
  p_no_access_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (!sram_rd && !sram_wr));
  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_rd && sram_wr));
endmodule

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl
  import nvc_pkg::*;
#(
  parameter int STORE_CYC  = 8,
  parameter int RECALL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic hsb_n_in,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic hsb_pull,
  output logic store_run,
  output logic recall_run,
  output logic sram_rd,
  output logic sram_wr,
  output logic dirty
);
  nv_state_t state;
  logic nv_done, power_up, store_req, idle;

  assign store_req = sw_store | ~hsb_n_in;
  assign idle      = (state == ST_IDLE);

  nvc_seq #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .store_req(store_req),
    .recall_req(sw_recall), .dirty(dirty), .state(state),
    .nv_done(nv_done), .power_up(power_up)
  );

  nvc_access u_access (
    .clk(clk), .rst_n(rst_n), .idle(idle), .power_up(power_up), .nv_done(nv_done),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hsb_n_in(hsb_n_in),
    .sram_rd(sram_rd), .sram_wr(sram_wr), .dirty(dirty)
  );

  assign store_run  = (state == ST_STORE);
  assign recall_run = (state == ST_RECALL);
  assign hsb_pull   = store_run | recall_run;

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hsb_pull |-> (!sram_rd && !sram_wr));
endmodule

// File: tb/tb_nvstore_ctrl.sv
module tb_nvstore_ctrl;
  localparam int SC = 6;
  localparam int RC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_ok = 0, hsb_n_in = 1, sw_store = 0, sw_recall = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic hsb_pull, store_run, recall_run, sram_rd, sram_wr, dirty;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nvstore_ctrl #(.STORE_CYC(SC), .RECALL_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .hsb_n_in(hsb_n_in),
    .sw_store(sw_store), .sw_recall(sw_recall), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hsb_pull(hsb_pull), .store_run(store_run), .recall_run(recall_run),
    .sram_rd(sram_rd), .sram_wr(sram_wr), .dirty(dirty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic measure(input bit st, output int n);
    n = 0;
    while ((st ? store_run : recall_run) && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write();
    ce_n = 0; we_n = 0;
    @(negedge clk);
    we_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    ce_n = 0; oe_n = 0; #1;
    chk("R6 reset read", sram_rd, 0);
    chk("R9 reset dirty", dirty, 0);
    chk("R1 reset busy", hsb_pull, 0);
    chk("R1 reset run", store_run | recall_run, 0);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic t_powerup_lock();
    int n;
    ce_n = 0; we_n = 0; pwr_ok = 1;
    @(negedge clk);
    chk("R11 busy in recall", hsb_pull, 1);
    chk("R11 no write in recall", sram_wr, 0);
    measure(0, n);
    chk("R1 recall length", n, RC);
    #1 chk("R8 held we stays locked", sram_wr, 0);
    @(negedge clk);
    chk("R8 dirty while locked", dirty, 0);
    we_n = 1;
    @(negedge clk);
    we_n = 0; #1;
    chk("R8 fresh edge write", sram_wr, 1);
    @(negedge clk);
    we_n = 1; ce_n = 1;
    chk("R9 dirty after write", dirty, 1);
  endtask

  task automatic t_read_hwstore();
    int n;
    ce_n = 0; oe_n = 0; #1;
    chk("R6 read allowed", sram_rd, 1);
    oe_n = 1; #1;
    chk("R6 read needs oe", sram_rd, 0);
    oe_n = 0; hsb_n_in = 0; #1;
    chk("R6 read needs hsb high", sram_rd, 0);
    @(negedge clk);
    hsb_n_in = 1;
    chk("R4 hw store started", store_run, 1);
    #1 chk("R11 no read in store", sram_rd, 0);
    measure(1, n);
    chk("R4 hw store length", n, SC);
    chk("R9 dirty cleared by store", dirty, 0);
    #1 chk("R4 idle after store", sram_rd, 1);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic t_clean_store();
    hsb_n_in = 0;
    @(negedge clk);
    hsb_n_in = 1; sw_store = 1;
    chk("R5 clean hw store skipped", store_run, 0);
    chk("R5 no busy pull", hsb_pull, 0);
    @(negedge clk);
    sw_store = 0;
    chk("R5 clean sw store skipped", store_run | hsb_pull, 0);
    @(negedge clk);
  endtask

  task automatic t_write_gates();
    ce_n = 0; we_n = 0; hsb_n_in = 0; #1;
    chk("R7 write needs hsb high", sram_wr, 0);
    @(negedge clk);
    we_n = 1; hsb_n_in = 1; ce_n = 1;
    chk("R7 blocked write leaves dirty", dirty, 0);
    chk("R5 hsb store clean skipped", store_run, 0);
    we_n = 0; #1;
    chk("R7 write needs ce", sram_wr, 0);
    @(negedge clk);
    we_n = 1;
    chk("R7 dirty unchanged", dirty, 0);
    @(negedge clk);
  endtask

  task automatic t_sw_store();
    int n;
    do_write();
    chk("R9 dirty set", dirty, 1);
    sw_store = 1;
    @(negedge clk);
    sw_store = 0;
    chk("R4 sw store started", store_run, 1);
    measure(1, n);
    chk("R4 sw store length", n, SC);
    chk("R9 dirty cleared", dirty, 0);
  endtask

  task automatic t_priority();
    int n;
    do_write();
    sw_store = 1; sw_recall = 1;
    @(negedge clk);
    sw_store = 0; sw_recall = 0;
    chk("R12 store wins", store_run, 1);
    chk("R12 recall not run", recall_run, 0);
    measure(1, n);
    chk("R12 store length", n, SC);
    @(negedge clk);
    chk("R12 recall dropped", recall_run, 0);
  endtask

  task automatic t_sw_recall();
    int n;
    do_write();
    sw_recall = 1;
    @(negedge clk);
    sw_recall = 0; sw_store = 1;
    chk("R10 recall started", recall_run, 1);
    ce_n = 0; oe_n = 0; #1;
    chk("R11 no read in recall", sram_rd, 0);
    @(negedge clk);
    sw_store = 0;
    measure(0, n);
    chk("R10 recall length", n + 1, RC);
    chk("R10 dirty cleared", dirty, 0);
    chk("R11 no queued store", store_run, 0);
    #1 chk("R10 idle read", sram_rd, 1);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    chk("R11 still no store", store_run | hsb_pull, 0);
  endtask

  task automatic t_powerfail();
    int n;
    do_write();
    pwr_ok = 0;
    @(negedge clk);
    chk("R2 auto store started", store_run, 1);
    measure(1, n);
    chk("R2 auto store length", n, SC);
    chk("R2 down no runs", store_run | recall_run, 0);
    chk("R2 down no busy", hsb_pull, 0);
    ce_n = 0; oe_n = 0; #1;
    chk("R2 down no read", sram_rd, 0);
    ce_n = 1; oe_n = 1;
    chk("R9 dirty after auto store", dirty, 0);
  endtask

  task automatic t_powerfail_clean();
    int n;
    pwr_ok = 1;
    @(negedge clk);
    measure(0, n);
    chk("R1 second recall length", n, RC);
    pwr_ok = 0;
    @(negedge clk);
    chk("R3 clean no store", store_run, 0);
    chk("R3 no busy", hsb_pull, 0);
    @(negedge clk);
    chk("R3 stays down", store_run | recall_run, 0);
    ce_n = 0; oe_n = 0; #1;
    chk("R3 down no read", sram_rd, 0);
    ce_n = 1; oe_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_powerup_lock();
    t_read_hwstore();
    t_clean_store();
    t_write_gates();
    t_sw_store();
    t_priority();
    t_sw_recall();
    t_powerfail();
    t_powerfail_clean();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule